// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a synchronous request port and an asynchronous static RAM with a 21-bit address, an 8-bit bidirectional data bus, a pair of chip selects of opposite polarity (one active-low, one active-high), and active-low write-enable and output-enable strobes. A requester offers one word at a time on a valid/ready handshake. Each request carries an address, write data and a direction flag. A completed read returns its byte with a single-cycle valid pulse.

The memory has minimum times for the read cycle, the write pulse, the data setup before the write ends, and the release of its outputs after output-enable goes high. Every one of these is converted to a whole number of clock cycles by rounding up from a clock-period parameter. A read holds the selects and output-enable for the read-cycle count, registers the bus on its last cycle, and then waits out a bus-release gap before it accepts the next request. A write selects the part and drives the data one cycle before write-enable falls. It keeps write-enable low for the pulse count, raises write-enable while the selects and the data are still held, and then releases everything. Between operations the memory is deselected, so it drops into standby.

With the default 10 ns clock, a read occupies 6 access cycles plus 2 turnaround cycles, and a write occupies 1 setup cycle, 4 pulse cycles and 1 hold cycle.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is asserted and after its release, the memory is deselected (`sramCe1N`=1, `sramCe2`=0), `sramWeN`=1, `sramOeN`=1, `sramDqOe`=0 and `reqReady`=1.
- R2: Address, write data and direction are captured on the edge where `reqValid` and `reqReady` are both 1. `sramAddr` keeps the captured address for the whole operation, even if the request inputs change afterwards.
- R3: A read drives `sramCe1N`=0, `sramCe2`=1, `sramOeN`=0 and `sramWeN`=1 for RD = ceil(55 ns / period) cycles, starting in the cycle after acceptance. `sramDqIn` is registered on the last of those cycles and shown on `rdData` with `rdValid`=1 for exactly one cycle, RD+1 cycles after acceptance.
- R4: After a read, the memory is deselected with `sramOeN`=1 and `sramDqOe`=0 for TA = ceil(20 ns / period) cycles. The data bus is not driven again until more than TA cycles have passed since the memory stopped driving.
- R5: A write runs as 1 setup cycle (selected, `sramWeN`=1, data driven), then WP cycles with `sramWeN`=0, then 1 hold cycle (selected, `sramWeN`=1, data still driven). WP is the largest of ceil(40/period), ceil(25/period), ceil(40/period) and ceil(55/period)-2. `sramDqOut` carries the captured data throughout.
- R6: Whenever `sramWeN` is 0, `sramOeN` is 1, `sramDqOe` is 1 and both selects are active.
- R7: `reqReady` goes low in the cycle after acceptance and returns to 1 after RD+TA cycles for a read and WP+2 cycles for a write.
- R8: `rdValid` is never asserted during or after a write.
- R9: Whenever `reqReady` is 1, the memory is deselected and the bus is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Request can be accepted |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 21 | Word address |
| reqWdata | input | 8 | Write data |
| rdValid | output | 1 | One-cycle read-data strobe |
| rdData | output | 8 | Registered read data |
| sramAddr | output | 21 | Memory address pins |
| sramCe1N | output | 1 | Active-low chip select |
| sramCe2 | output | 1 | Active-high chip select |
| sramWeN | output | 1 | Active-low write enable |
| sramOeN | output | 1 | Active-low output enable |
| sramDqOut | output | 8 | Data toward the memory |
| sramDqOe | output | 1 | Enable for the data-bus tristate driver |
| sramDqIn | input | 8 | Data from the memory bus |

## Verification
A phase counter that is off by one shows up immediately at the ports. A short read registers a byte before the memory model's access time has elapsed, so `rdData` comes back inverted. A short turnaround lets the bus be driven while the model may still hold it, and a short write pulse is caught by the model's write-timing check when the write ends. A wrong state transition changes the cycle on which `rdValid` pulses or `reqReady` returns, and each operation's timing is checked to the exact cycle. A failure to capture the address shows up as a changed `sramAddr` one cycle after acceptance, when the bench alters the request inputs.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_READ,
    PH_TURN,
    PH_WSET,
    PH_WPULSE,
    PH_WHOLD
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;   // request taken this cycle
    logic capture;  // register read bus this cycle
    logic select;   // memory selected
    logic readEn;   // output enable asserted
    logic writeEn;  // write enable asserted
    logic drive;    // controller drives data bus
  } strobe_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_fsm.sv
module asram_fsm
  import asram_pkg::*;
#(
  parameter int CLK_NS  = 10,
  parameter int T_RC_NS = 55,
  parameter int T_WC_NS = 55,
  parameter int T_WP_NS = 40,
  parameter int T_AW_NS = 40,
  parameter int T_DS_NS = 25,
  parameter int T_HZ_NS = 20
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output strobe_t stb
);

  localparam int RD_CYC  = maxOf(ceilDiv(T_RC_NS, CLK_NS), 1);
  localparam int TA_CYC  = maxOf(ceilDiv(T_HZ_NS, CLK_NS), 1);
  localparam int WP_A    = maxOf(ceilDiv(T_WP_NS, CLK_NS), ceilDiv(T_DS_NS, CLK_NS));
  localparam int WP_B    = maxOf(ceilDiv(T_AW_NS, CLK_NS), ceilDiv(T_WC_NS, CLK_NS) - 2);
  localparam int WP_CYC  = maxOf(maxOf(WP_A, WP_B), 1);
  localparam int MAX_CYC = maxOf(maxOf(RD_CYC, TA_CYC), WP_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  phase_t            phase;
  logic [CNT_W-1:0]  cnt;
  logic              cntZero;

  assign cntZero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (reqValid) begin
            if (reqWrite) begin
              phase <= PH_WSET;
              cnt   <= '0;
            end else begin
              phase <= PH_READ;
              cnt   <= CNT_W'(RD_CYC - 1);
            end
          end
        end
        PH_READ: begin
          if (cntZero) begin
            phase <= PH_TURN;
            cnt   <= CNT_W'(TA_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_TURN: begin
          if (cntZero) phase <= PH_IDLE;
          else         cnt   <= cnt - 1'b1;
        end
        PH_WSET: begin
          phase <= PH_WPULSE;
          cnt   <= CNT_W'(WP_CYC - 1);
        end
        PH_WPULSE: begin
          if (cntZero) phase <= PH_WHOLD;
          else         cnt   <= cnt - 1'b1;
        end
        PH_WHOLD: phase <= PH_IDLE;
        default:  phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    reqReady    = (phase == PH_IDLE);
    stb.accept  = reqReady && reqValid;
    stb.capture = (phase == PH_READ) && cntZero;
    stb.select  = (phase == PH_READ) || (phase == PH_WSET) ||
                  (phase == PH_WPULSE) || (phase == PH_WHOLD);
    stb.readEn  = (phase == PH_READ);
    stb.writeEn = (phase == PH_WPULSE);
    stb.drive   = (phase == PH_WSET) || (phase == PH_WPULSE) || (phase == PH_WHOLD);
  end

endmodule

// File: rtl/asram_dp.sv
module asram_dp
  import asram_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] sramAddr,
  output logic              sramCe1N,
  output logic              sramCe2,
  output logic              sramWeN,
  output logic              sramOeN,
  output logic [DATA_W-1:0] sramDqOut,
  output logic              sramDqOe,
  input  logic [DATA_W-1:0] sramDqIn
);

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wdataReg;
  logic [DATA_W-1:0] rdReg;
  logic              rdValidReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg    <= '0;
      wdataReg   <= '0;
      rdReg      <= '0;
      rdValidReg <= 1'b0;
    end else begin
      if (stb.accept) begin
        addrReg  <= reqAddr;
        wdataReg <= reqWdata;
      end
      if (stb.capture) rdReg <= sramDqIn;
      rdValidReg <= stb.capture;
    end
  end

  // pin polarity mapping
  assign sramAddr  = addrReg;
  assign sramCe1N  = ~stb.select;
  assign sramCe2   = stb.select;
  assign sramWeN   = ~stb.writeEn;
  assign sramOeN   = ~stb.readEn;
  assign sramDqOut = wdataReg;
  assign sramDqOe  = stb.drive;
  assign rdData    = rdReg;
  assign rdValid   = rdValidReg;

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W  = 21,
  parameter int DATA_W  = 8,
  parameter int CLK_NS  = 10,
  parameter int T_RC_NS = 55,
  parameter int T_WC_NS = 55,
  parameter int T_WP_NS = 40,
  parameter int T_AW_NS = 40,
  parameter int T_DS_NS = 25,
  parameter int T_HZ_NS = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] sramAddr,
  output logic              sramCe1N,
  output logic              sramCe2,
  output logic              sramWeN,
  output logic              sramOeN,
  output logic [DATA_W-1:0] sramDqOut,
  output logic              sramDqOe,
  input  logic [DATA_W-1:0] sramDqIn
);

  strobe_t stb;

  asram_fsm #(
    .CLK_NS (CLK_NS),
    .T_RC_NS(T_RC_NS),
    .T_WC_NS(T_WC_NS),
    .T_WP_NS(T_WP_NS),
    .T_AW_NS(T_AW_NS),
    .T_DS_NS(T_DS_NS),
    .T_HZ_NS(T_HZ_NS)
  ) u_fsm (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .stb     (stb)
  );

  asram_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .rdValid  (rdValid),
    .rdData   (rdData),
    .sramAddr (sramAddr),
    .sramCe1N (sramCe1N),
    .sramCe2  (sramCe2),
    .sramWeN  (sramWeN),
    .sramOeN  (sramOeN),
    .sramDqOut(sramDqOut),
    .sramDqOe (sramDqOe),
    .sramDqIn (sramDqIn)
  );

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk
  import asram_pkg::*;
#(
  parameter int ADDR_W  = 21,
  parameter int CLK_NS  = 10,
  parameter int T_HZ_NS = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rdValid,
  input logic [ADDR_W-1:0] sramAddr,
  input logic              sramCe1N,
  input logic              sramCe2,
  input logic              sramWeN,
  input logic              sramOeN,
  input logic              sramDqOe
);

  localparam int TURN = maxOf(ceilDiv(T_HZ_NS, CLK_NS), 1);

  logic [7:0] sinceRead;

  always_ff @(posedge clk) begin
    if (!rstN)               sinceRead <= 8'hFF;
    else if (!sramOeN)       sinceRead <= 8'd0;
    else if (sinceRead != 8'hFF) sinceRead <= sinceRead + 8'd1;
  end

  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (sramCe1N && !sramCe2 && sramWeN && sramOeN && !sramDqOe));

  a_r2_addr_held: assert property (@(posedge clk) disable iff (!rstN)
    (!reqReady && $past(!reqReady)) |-> $stable(sramAddr));

  a_r3_capture_in_read: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(!sramOeN && !sramCe1N && sramCe2 && sramWeN));

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

  a_r4_turnaround: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramDqOe) |-> (sinceRead >= 8'(TURN)));

  a_r5_data_before_pulse: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sramWeN) |-> $past(sramDqOe));

  a_r6_write_pins: assert property (@(posedge clk) disable iff (!rstN)
    !sramWeN |-> (sramOeN && sramDqOe && !sramCe1N && sramCe2));

  a_r8_no_valid_after_write: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(sramWeN && !sramDqOe));

endmodule

bind asram_ctrl asram_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .CLK_NS (CLK_NS),
  .T_HZ_NS(T_HZ_NS)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .reqReady(reqReady),
  .rdValid (rdValid),
  .sramAddr(sramAddr),
  .sramCe1N(sramCe1N),
  .sramCe2 (sramCe2),
  .sramWeN (sramWeN),
  .sramOeN (sramOeN),
  .sramDqOe(sramDqOe)
);

// File: tb/asram_ctrl_bench.sv
module asram_ctrl_bench;

  localparam int CLK_NS = 10;
  localparam int RD_E   = (55 + CLK_NS - 1) / CLK_NS;
  localparam int TA_E   = (20 + CLK_NS - 1) / CLK_NS;
  localparam int WPM_E  = (40 + CLK_NS - 1) / CLK_NS;
  localparam int DS_E   = (25 + CLK_NS - 1) / CLK_NS;
  localparam int WP_E   = (WPM_E > RD_E - 2) ? WPM_E : RD_E - 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [20:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        reqReady, rdValid;
  logic [7:0]  rdData;
  logic [20:0] sramAddr;
  logic        sramCe1N, sramCe2, sramWeN, sramOeN, sramDqOe;
  logic [7:0]  sramDqOut, sramDqIn;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  asram_ctrl u_asram_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rdValid(rdValid), .rdData(rdData), .sramAddr(sramAddr),
    .sramCe1N(sramCe1N), .sramCe2(sramCe2), .sramWeN(sramWeN),
    .sramOeN(sramOeN), .sramDqOut(sramDqOut), .sramDqOe(sramDqOe),
    .sramDqIn(sramDqIn)
  );

  // ---------------- memory model ----------------
  logic [7:0]  mem [256];
  logic [7:0]  shadow [256];
  logic        modelDrive, wrNow, wasWr, prevOe;
  logic [7:0]  lastDq;
  logic [20:0] lastAddr, wrAddr;
  int          rdAge, hizCnt, weLow, dStable, busErr, wrErr;

  assign modelDrive = !sramCe1N && sramCe2 && !sramOeN && sramWeN;
  assign wrNow      = !sramCe1N && sramCe2 && !sramWeN;
  assign sramDqIn   = !modelDrive ? 8'h00 :
                      (rdAge >= RD_E - 1) ? mem[sramAddr[7:0]] : ~mem[sramAddr[7:0]];

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 7 + 3);
      rdAge <= 0; hizCnt <= 15; weLow <= 0; dStable <= 0;
      busErr <= 0; wrErr <= 0; wasWr <= 1'b0; prevOe <= 1'b0;
      lastDq <= '0; lastAddr <= '0; wrAddr <= '0;
    end else begin
      if (modelDrive) begin
        rdAge  <= (sramAddr == lastAddr) ? rdAge + 1 : 1;
        hizCnt <= 0;
      end else begin
        rdAge <= 0;
        if (hizCnt < 15) hizCnt <= hizCnt + 1;
      end
      if (sramDqOe && (modelDrive || hizCnt <= TA_E)) busErr <= busErr + 1;
      if (sramDqOe) dStable <= (prevOe && sramDqOut == lastDq) ? dStable + 1 : 1;
      else          dStable <= 0;
      if (wrNow) begin
        weLow  <= wasWr ? weLow + 1 : 1;
        wrAddr <= sramAddr;
      end else if (wasWr) begin
        if (weLow < WPM_E || dStable < DS_E || sramAddr != wrAddr) wrErr <= wrErr + 1;
        mem[wrAddr[7:0]] <= lastDq;
      end
      wasWr    <= wrNow;
      prevOe   <= sramDqOe;
      lastDq   <= sramDqOut;
      lastAddr <= sramAddr;
    end
  end

  // ---------------- checking helpers ----------------
  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic checkIdle(input string tag);
    check(sramCe1N && !sramCe2 && sramWeN && sramOeN && !sramDqOe, tag,
          {sramCe1N, sramCe2, sramWeN, sramOeN, sramDqOe}, 5'b10110);
  endtask

  task automatic doWrite(input logic [20:0] a, input logic [7:0] d);
    int k, low, r6bad, r8bad;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0; reqAddr = ~a; reqWdata = ~d;
    check(sramAddr == a, "R2 write address captured", int'(sramAddr), int'(a));
    check(!sramCe1N && sramCe2 && sramWeN && sramOeN && sramDqOe && sramDqOut == d,
          "R5 setup cycle", int'(sramDqOut), int'(d));
    k = 1; low = 0; r6bad = 0; r8bad = 0;
    while (!reqReady && k < 100) begin
      if (!sramWeN) begin
        low++;
        if (!(sramOeN && sramDqOe && !sramCe1N && sramCe2)) r6bad++;
      end
      if (rdValid) r8bad++;
      if (k == WP_E + 2)
        check(sramWeN && sramDqOe && !sramCe1N && sramCe2 && sramDqOut == d,
              "R5 hold cycle", int'(sramWeN), 1);
      @(negedge clk); k++;
    end
    if (rdValid) r8bad++;
    check(low == WP_E, "R5 write pulse length", low, WP_E);
    check(r6bad == 0, "R6 pins during write pulse", r6bad, 0);
    check(r8bad == 0, "R8 no read strobe on write", r8bad, 0);
    check(k == WP_E + 3, "R7 write busy time", k, WP_E + 3);
    checkIdle("R9 standby after write");
    shadow[a[7:0]] = d;
  endtask

  task automatic doRead(input logic [20:0] a);
    int k, vAt, pulses;
    logic [7:0] got;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a;
    @(negedge clk);
    reqValid = 1'b0; reqAddr = ~a; reqWrite = 1'b1;
    check(sramAddr == a, "R2 read address captured", int'(sramAddr), int'(a));
    check(!sramCe1N && sramCe2 && !sramOeN && sramWeN && !sramDqOe,
          "R3 read pins", int'(sramOeN), 0);
    k = 1; vAt = 0; pulses = 0; got = '0;
    while (!reqReady && k < 100) begin
      if (rdValid) begin pulses++; vAt = k; got = rdData; end
      if (k == RD_E + 1)
        check(sramCe1N && !sramCe2 && sramOeN && !sramDqOe, "R4 turnaround released",
              int'(sramDqOe), 0);
      @(negedge clk); k++;
    end
    if (rdValid) pulses++;
    check(vAt == RD_E + 1, "R3 read strobe timing", vAt, RD_E + 1);
    check(pulses == 1, "R3 single read strobe", pulses, 1);
    check(got == shadow[a[7:0]], "R3 read data", int'(got), int'(shadow[a[7:0]]));
    check(k == RD_E + TA_E + 1, "R7 read busy time", k, RD_E + TA_E + 1);
    checkIdle("R9 standby after read");
  endtask

  function automatic logic [20:0] addrOf(input int i);
    return 21'((i * 32'h0F1A3) ^ (i << 13));
  endfunction

  // ---------------- stimulus ----------------
  initial begin
    for (int i = 0; i < 256; i++) shadow[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    checkIdle("R1 state in reset");
    rstN = 1'b1;
    @(negedge clk);
    checkIdle("R1 state after reset");
    check(reqReady == 1'b1, "R1 ready after reset", int'(reqReady), 1);

    // reads of untouched locations
    for (int i = 0; i < 8; i++) doRead(addrOf(i + 100));
    // write sweep then read-back sweep
    for (int i = 0; i < 32; i++) doWrite(addrOf(i), 8'(i * 37 + 5));
    for (int i = 0; i < 32; i++) doRead(addrOf(i));
    // interleaved write/read on the same location, extreme data
    for (int i = 0; i < 16; i++) begin
      doWrite(addrOf(i + 40), (i % 2 == 0) ? 8'hFF : 8'h00);
      doRead(addrOf(i + 40));
      doRead(addrOf(i + 40) ^ 21'h1F0000);
    end
    // back-to-back reads then writes
    for (int i = 0; i < 4; i++) begin
      doRead(21'h1FFFFF);
      doRead(21'h000000);
      doWrite(21'h1FFFFF, 8'(8'hA5 + i));
      doWrite(21'h000000, 8'(8'h5A - i));
    end
    doRead(21'h1FFFFF);
    doRead(21'h000000);

    repeat (4) @(negedge clk);
    check(busErr == 0, "R4 bus driven during release window", busErr, 0);
    check(wrErr == 0, "R5 write timing at memory", wrErr, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule